// File: doc/BRIEF.md
# Serial-Bus Node Core Register File

This block answers single-quadlet read and write requests that target the core control and status window of a serial-bus node. A request carries a 12-bit byte offset into the window, a byte length and, for writes, one 32-bit data word. Each accepted request produces exactly one response with a 3-bit result code and 32 bits of read data. The codes are 0 for complete, 6 for type error and 7 for address error. The block keeps the bus field of the node ID, the two split-timeout words, the bus-time extension of an external cycle counter and the broadcast-channel word. It also presents the split-timeout expiry as a count of 125 µs units.

The isochronous resource words (bus manager, bandwidth and the two channel masks) are served by another block. Here they are only decoded so that plain reads and writes to them are refused. The node state word is supplied from outside and read back through both state offsets. Writes to those offsets, and to the reset-start offset, are acknowledged and change nothing.

Requests and responses each use a valid/ready handshake. The block takes a request only while its response slot is empty or is being drained in the same cycle. So when the response consumer stalls, `req_ready` falls and the requester must hold its request until it rises again. A response stays unchanged until the cycle in which `rsp_ready` is high.

Top module: `sbn_csr_regfile`

## Requirements
- R1: `req_ready` is high exactly when no response is pending or the pending one is taken in the same cycle. A request accepted on a clock edge has its response valid from that edge, and while `rsp_valid` is high with `rsp_ready` low, the code and data hold still.
- R2: If bit 0 or bit 1 of the offset is set, or bit 0 or bit 1 of the length is set, the response is code 6 with data 0, and no register changes.
- R3: After reset, split-timeout high reads 0 and low reads 800<<19, and `split_expiry` is 800. The bus field (`bus_id_out`) is 0x3FF, bus time is 0 and broadcast channel reads 0x8000001F.
- R4: Split-timeout high lives at 0x018 and keeps only written bits [2:0]. Split-timeout low lives at 0x01C and keeps only bits [31:19]. `split_expiry` equals (high[2:0]<<13) + (low>>19) from the cycle after either write.
- R5: A complete read of cycle time (0x200) or bus time (0x204) samples `cyc_count_in`. If the sample is below the previous sample, bus time first grows by 128. A cycle-time read returns the sample itself.
- R6: A bus-time read returns bus time OR (sample>>25). A bus-time write keeps bits [31:7]. A cycle-time write pulses `cyc_load` for one cycle, alongside the response, with the full word on `cyc_load_data`, and that word becomes the previous sample.
- R7: Node IDs (0x008) reads {bus[9:0], `node_num_in`[5:0], 16'h0}. A write replaces only the bus field from data bits [31:22].
- R8: Broadcast channel (0x234) is changed by a write only in bit 30. Every other bit keeps its value.
- R9: State offsets 0x000 and 0x004 read `state_word_in`. Writes to them, and to reset-start (0x00C), complete with no effect. A reset-start read, and any read or write of 0x21C, 0x220, 0x224 or 0x228, gives code 6.
- R10: Busy-timeout (0x210) and every offset not listed above give code 7. Every error response and every write response carries data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 12 | Byte offset into the register window |
| req_len | input | 12 | Request length in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_code | output | 3 | 0 complete, 6 type error, 7 address error |
| rsp_rdata | output | 32 | Read data |
| state_word_in | input | 32 | Node state word returned by state reads |
| node_num_in | input | 6 | Physical node number |
| cyc_count_in | input | 32 | Live external cycle counter |
| cyc_load | output | 1 | One-cycle pulse: load counter |
| cyc_load_data | output | 32 | Value to load into the counter |
| bus_id_out | output | 10 | Current bus field of the node ID |
| split_expiry | output | 16 | Split-timeout expiry in 125 µs units |

## Verification
A single bus-time read can carry out wrap detection and readout in the same cycle. In that case the returned word must already contain the 128 added by a wrap found in that very sample, together with the top seven bits of the new sample. The bench provokes this directly by reading cycle time with a high counter value and then bus time with a lower one. The random phase also lets the counter fall back now and then between mixed cycle-time and bus-time reads. The judgement comes from a bench model that adds the step before forming the read word. A further case holds a node-ID write waiting behind a stalled response, to show that it takes effect only once accepted.

// File: rtl/sbn_csr_pkg.sv
`timescale 1ns/1ps
package sbn_csr_pkg;

  typedef enum logic [2:0] {
    RSP_COMPLETE = 3'd0,
    RSP_TYPE_ERR = 3'd6,
    RSP_ADDR_ERR = 3'd7
  } rsp_code_e;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_STATE,
    SEL_NODE_IDS,
    SEL_RESET_GO,
    SEL_SPLIT_HI,
    SEL_SPLIT_LO,
    SEL_CYCLE,
    SEL_BUSTIME,
    SEL_ISO,
    SEL_BCAST
  } reg_sel_e;

  localparam logic [11:0] OFS_STATE_CLR  = 12'h000;
  localparam logic [11:0] OFS_STATE_SET  = 12'h004;
  localparam logic [11:0] OFS_NODE_IDS   = 12'h008;
  localparam logic [11:0] OFS_RESET_GO   = 12'h00C;
  localparam logic [11:0] OFS_SPLIT_HI   = 12'h018;
  localparam logic [11:0] OFS_SPLIT_LO   = 12'h01C;
  localparam logic [11:0] OFS_CYCLE      = 12'h200;
  localparam logic [11:0] OFS_BUSTIME    = 12'h204;
  localparam logic [11:0] OFS_BUSY_TMO   = 12'h210;
  localparam logic [11:0] OFS_ISO_FIRST  = 12'h21C;
  localparam logic [11:0] OFS_ISO_LAST   = 12'h228;
  localparam logic [11:0] OFS_BCAST      = 12'h234;

  localparam logic [31:0] BCAST_RESET    = 32'h8000_001F;
  localparam int unsigned BCAST_VALID_BIT = 30;

endpackage

// File: rtl/sbn_csr_decode.sv
`timescale 1ns/1ps
module sbn_csr_decode
  import sbn_csr_pkg::*;
#(
  parameter int OFS_W = 12,
  parameter int LEN_W = 12
) (
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             wr_i,
  output reg_sel_e         sel_o,
  output rsp_code_e        code_o
);

  logic misalign;
  assign misalign = (ofs_i[1:0] != 2'b00) || (len_i[1:0] != 2'b00);

  always_comb begin
    sel_o  = SEL_NONE;
    code_o = RSP_ADDR_ERR;
    if (misalign) begin
      code_o = RSP_TYPE_ERR;
    end else begin
      unique case (ofs_i)
        OFS_STATE_CLR, OFS_STATE_SET: begin
          sel_o = SEL_STATE; code_o = RSP_COMPLETE;
        end
        OFS_NODE_IDS: begin
          sel_o = SEL_NODE_IDS; code_o = RSP_COMPLETE;
        end
        OFS_RESET_GO: begin
          sel_o  = SEL_RESET_GO;
          code_o = wr_i ? RSP_COMPLETE : RSP_TYPE_ERR;
        end
        OFS_SPLIT_HI: begin
          sel_o = SEL_SPLIT_HI; code_o = RSP_COMPLETE;
        end
        OFS_SPLIT_LO: begin
          sel_o = SEL_SPLIT_LO; code_o = RSP_COMPLETE;
        end
        OFS_CYCLE: begin
          sel_o = SEL_CYCLE; code_o = RSP_COMPLETE;
        end
        OFS_BUSTIME: begin
          sel_o = SEL_BUSTIME; code_o = RSP_COMPLETE;
        end
        OFS_BCAST: begin
          sel_o = SEL_BCAST; code_o = RSP_COMPLETE;
        end
        default: begin
          if (ofs_i >= OFS_ISO_FIRST && ofs_i <= OFS_ISO_LAST) begin
            sel_o  = SEL_ISO;
            code_o = RSP_TYPE_ERR;
          end else begin
            sel_o  = SEL_NONE;
            code_o = RSP_ADDR_ERR;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/sbn_csr_split_timer.sv
`timescale 1ns/1ps
module sbn_csr_split_timer #(
  parameter int SEC_W  = 3,
  parameter int FRAC_W = 13,
  parameter int FRAC_RESET = 800,
  localparam int EXP_W = SEC_W + FRAC_W,
  localparam int FRAC_LSB = 32 - FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hi_i,
  input  logic             wr_lo_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      hi_o,
  output logic [31:0]      lo_o,
  output logic [EXP_W-1:0] expiry_o
);

  logic [SEC_W-1:0]  sec_q;
  logic [FRAC_W-1:0] frac_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      frac_q <= FRAC_W'(FRAC_RESET);
    end else begin
      if (wr_hi_i) sec_q  <= wdata_i[SEC_W-1:0];
      if (wr_lo_i) frac_q <= wdata_i[31:FRAC_LSB];
    end
  end

  assign hi_o     = {{(32-SEC_W){1'b0}}, sec_q};
  assign lo_o     = {frac_q, {FRAC_LSB{1'b0}}};
  assign expiry_o = {sec_q, {FRAC_W{1'b0}}} + {{SEC_W{1'b0}}, frac_q};

endmodule

// File: rtl/sbn_csr_bus_time.sv
`timescale 1ns/1ps
module sbn_csr_bus_time #(
  parameter int EXT_LSB = 7,
  parameter int CYC_SHIFT = 25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sample_en_i,
  input  logic        bt_wr_i,
  input  logic        ct_wr_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] cyc_count_i,
  output logic [31:0] bt_read_o,
  output logic [31:0] bus_time_o,
  output logic        cyc_load_o,
  output logic [31:0] cyc_load_data_o
);

  localparam logic [31:0] STEP = 32'd1 << EXT_LSB;
  localparam logic [31:0] EXT_MASK = ~(STEP - 32'd1);

  logic [31:0] bt_q;
  logic [31:0] last_q;
  logic        wrap;
  logic [31:0] bt_next;

  assign wrap      = sample_en_i && (cyc_count_i < last_q);
  assign bt_next   = wrap ? bt_q + STEP : bt_q;
  assign bt_read_o = bt_next | (cyc_count_i >> CYC_SHIFT);
  assign bus_time_o = bt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bt_q            <= '0;
      last_q          <= '0;
      cyc_load_o      <= 1'b0;
      cyc_load_data_o <= '0;
    end else begin
      cyc_load_o <= ct_wr_i;
      if (sample_en_i) begin
        last_q <= cyc_count_i;
        bt_q   <= bt_next;
      end
      if (bt_wr_i) bt_q <= wdata_i & EXT_MASK;
      if (ct_wr_i) begin
        last_q          <= wdata_i;
        cyc_load_data_o <= wdata_i;
      end
    end
  end

endmodule

// File: rtl/sbn_csr_regfile.sv
`timescale 1ns/1ps
module sbn_csr_regfile
  import sbn_csr_pkg::*;
#(
  parameter int OFS_W  = 12,
  parameter int LEN_W  = 12,
  parameter int BUS_W  = 10,
  parameter int NODE_W = 6,
  parameter int SEC_W  = 3,
  parameter int FRAC_W = 13,
  localparam int EXP_W = SEC_W + FRAC_W,
  localparam int ID_LSB = 32 - BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_code,
  output logic [31:0]       rsp_rdata,
  input  logic [31:0]       state_word_in,
  input  logic [NODE_W-1:0] node_num_in,
  input  logic [31:0]       cyc_count_in,
  output logic              cyc_load,
  output logic [31:0]       cyc_load_data,
  output logic [BUS_W-1:0]  bus_id_out,
  output logic [EXP_W-1:0]  split_expiry
);

  reg_sel_e  sel;
  rsp_code_e code;
  logic      fire, ok;
  logic      rd_ok, wr_ok;
  logic [31:0] split_hi, split_lo, bt_read, bus_time_q;
  logic [BUS_W-1:0] bus_q;
  logic [31:0] bcast_q;
  logic [31:0] rdata_n;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign ok        = (code == RSP_COMPLETE);
  assign rd_ok     = fire && ok && !req_write;
  assign wr_ok     = fire && ok && req_write;

  sbn_csr_decode #(.OFS_W(OFS_W), .LEN_W(LEN_W)) u_dec (
    .ofs_i (req_offset),
    .len_i (req_len),
    .wr_i  (req_write),
    .sel_o (sel),
    .code_o(code)
  );

  sbn_csr_split_timer #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_split (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hi_i (wr_ok && sel == SEL_SPLIT_HI),
    .wr_lo_i (wr_ok && sel == SEL_SPLIT_LO),
    .wdata_i (req_wdata),
    .hi_o    (split_hi),
    .lo_o    (split_lo),
    .expiry_o(split_expiry)
  );

  sbn_csr_bus_time u_btime (
    .clk            (clk),
    .rst_n          (rst_n),
    .sample_en_i    (rd_ok && (sel == SEL_CYCLE || sel == SEL_BUSTIME)),
    .bt_wr_i        (wr_ok && sel == SEL_BUSTIME),
    .ct_wr_i        (wr_ok && sel == SEL_CYCLE),
    .wdata_i        (req_wdata),
    .cyc_count_i    (cyc_count_in),
    .bt_read_o      (bt_read),
    .bus_time_o     (bus_time_q),
    .cyc_load_o     (cyc_load),
    .cyc_load_data_o(cyc_load_data)
  );

  always_comb begin
    rdata_n = '0;
    if (ok && !req_write) begin
      unique case (sel)
        SEL_STATE:    rdata_n = state_word_in;
        SEL_NODE_IDS: rdata_n = {bus_q, node_num_in, {(ID_LSB-NODE_W){1'b0}}};
        SEL_SPLIT_HI: rdata_n = split_hi;
        SEL_SPLIT_LO: rdata_n = split_lo;
        SEL_CYCLE:    rdata_n = cyc_count_in;
        SEL_BUSTIME:  rdata_n = bt_read;
        SEL_BCAST:    rdata_n = bcast_q;
        default:      rdata_n = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q   <= '1;
      bcast_q <= BCAST_RESET;
    end else begin
      if (wr_ok && sel == SEL_NODE_IDS) bus_q <= req_wdata[31:ID_LSB];
      if (wr_ok && sel == SEL_BCAST)
        bcast_q[BCAST_VALID_BIT] <= req_wdata[BCAST_VALID_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RSP_COMPLETE;
      rsp_rdata <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_code  <= code;
      rsp_rdata <= rdata_n;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign bus_id_out = bus_q;

endmodule

// File: rtl/sbn_csr_checker.sv
`timescale 1ns/1ps
module sbn_csr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [11:0] req_offset,
  input logic [11:0] req_len,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [2:0]  rsp_code,
  input logic [31:0] rsp_rdata,
  input logic        cyc_load,
  input logic [9:0]  bus_id_out,
  input logic [31:0] bus_time_q,
  input logic [31:0] bcast_q
);

  logic fire, aligned;
  assign fire    = req_valid && req_ready;
  assign aligned = (req_offset[1:0] == 2'b00) && (req_len[1:0] == 2'b00);

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_code) && $stable(rsp_rdata)); // R1

  AST_MISALIGN_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !aligned |=> rsp_code == 3'd6 && rsp_rdata == 32'd0); // R2

  AST_BT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && req_write && aligned && req_offset == 12'h204)
    |=> (bus_time_q == $past(bus_time_q)) || (bus_time_q == $past(bus_time_q) + 32'd128)); // R5

  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_load |-> $past(fire && req_write && aligned && req_offset == 12'h200)); // R6

  AST_BUSID_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && req_write && aligned && req_offset == 12'h008) |=> $stable(bus_id_out)); // R7

  AST_BCAST_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(bcast_q[29:0]) && bcast_q[31]); // R8

  AST_ISO_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    fire && aligned && req_offset >= 12'h21C && req_offset <= 12'h228 |=> rsp_code == 3'd6); // R9

endmodule

bind sbn_csr_regfile sbn_csr_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_offset(req_offset),
  .req_len   (req_len),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_code  (rsp_code),
  .rsp_rdata (rsp_rdata),
  .cyc_load  (cyc_load),
  .bus_id_out(bus_id_out),
  .bus_time_q(bus_time_q),
  .bcast_q   (bcast_q)
);

// File: tb/sbn_csr_regfile_test.sv
`timescale 1ns/1ps
module sbn_csr_regfile_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_offset = '0;
  logic [11:0] req_len = 12'd4;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [2:0]  rsp_code;
  logic [31:0] rsp_rdata;
  logic [31:0] state_word_in = 32'h0000_0300;
  logic [5:0]  node_num_in = 6'd5;
  logic [31:0] cyc_count_in = '0;
  logic        cyc_load;
  logic [31:0] cyc_load_data;
  logic [9:0]  bus_id_out;
  logic [15:0] split_expiry;

  always #4 clk = ~clk;

  sbn_csr_regfile uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_offset(req_offset), .req_len(req_len), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
    .rsp_rdata(rsp_rdata), .state_word_in(state_word_in), .node_num_in(node_num_in),
    .cyc_count_in(cyc_count_in), .cyc_load(cyc_load), .cyc_load_data(cyc_load_data),
    .bus_id_out(bus_id_out), .split_expiry(split_expiry)
  );

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit done = 0;

  // reference state
  logic [9:0]  m_bus;
  logic [31:0] m_hi, m_lo, m_bt, m_last, m_bcast;

  function automatic logic [15:0] exp_expiry();
    return 16'({m_hi[2:0], 13'd0}) + 16'(m_lo >> 19);
  endfunction

  task automatic chk(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input bit wr, input logic [11:0] ofs, input logic [11:0] len,
                       input logic [31:0] wd, input logic [31:0] cyc,
                       output logic [2:0] code, output logic [31:0] rd,
                       output bit load, output string tag);
    code = 3'd0; rd = '0; load = 0; tag = "R10";
    if (ofs[1:0] != 0 || len[1:0] != 0) begin
      code = 3'd6; tag = "R2";
    end else begin
      case (ofs)
        12'h000, 12'h004: begin tag = "R9"; if (!wr) rd = state_word_in; end
        12'h008: begin
          tag = "R7";
          if (wr) m_bus = wd[31:22]; else rd = {m_bus, node_num_in, 16'h0};
        end
        12'h00C: begin tag = "R9"; if (!wr) code = 3'd6; end
        12'h018: begin tag = "R4"; if (wr) m_hi = wd & 32'h7; else rd = m_hi; end
        12'h01C: begin tag = "R4"; if (wr) m_lo = wd & 32'hFFF8_0000; else rd = m_lo; end
        12'h200, 12'h204: begin
          if (wr) begin
            tag = "R6";
            if (ofs == 12'h200) begin load = 1; m_last = wd; end
            else m_bt = wd & 32'hFFFF_FF80;
          end else begin
            if (cyc < m_last) m_bt = m_bt + 32'd128;
            m_last = cyc;
            if (ofs == 12'h200) begin tag = "R5"; rd = cyc; end
            else begin tag = "R6"; rd = m_bt | (cyc >> 25); end
          end
        end
        12'h21C, 12'h220, 12'h224, 12'h228: begin tag = "R9"; code = 3'd6; end
        12'h234: begin
          tag = "R8";
          if (wr) m_bcast[30] = wd[30]; else rd = m_bcast;
        end
        default: code = 3'd7;
      endcase
    end
  endtask

  task automatic do_req(input bit wr, input logic [11:0] ofs, input logic [11:0] len,
                        input logic [31:0] wd, input logic [31:0] cyc);
    logic [2:0] ec; logic [31:0] er; bit el; string tag;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_offset = ofs; req_len = len;
    req_wdata = wd; cyc_count_in = cyc;
    model(wr, ofs, len, wd, cyc, ec, er, el, tag);
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid === 1'b1, "R1 rsp_valid", 32'(rsp_valid), 32'd1);
    chk(rsp_code === ec, {tag, " code"}, 32'(rsp_code), 32'(ec));
    chk(rsp_rdata === er, {tag, " data"}, rsp_rdata, er);
    chk(cyc_load === el, "R6 load pulse", 32'(cyc_load), 32'(el));
    if (el) chk(cyc_load_data === wd, "R6 load data", cyc_load_data, wd);
    chk(split_expiry === exp_expiry(), "R4 expiry", 32'(split_expiry), 32'(exp_expiry()));
    chk(bus_id_out === m_bus, "R7 bus id", 32'(bus_id_out), 32'(m_bus));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  logic [11:0] offs [16] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h018, 12'h01C,
                             12'h200, 12'h204, 12'h210, 12'h21C, 12'h220, 12'h224,
                             12'h228, 12'h234, 12'h010, 12'h3FC};

  initial begin
    void'($urandom(32'd1394));
    m_bus = 10'h3FF; m_hi = 0; m_lo = 32'd800 << 19; m_bt = 0; m_last = 0;
    m_bcast = 32'h8000_001F;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R3 reset state
    chk(split_expiry === 16'd800, "R3 expiry reset", 32'(split_expiry), 32'd800);
    chk(bus_id_out === 10'h3FF, "R3 bus reset", 32'(bus_id_out), 32'h3FF);
    chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R1 idle", 32'(rsp_valid), 32'd0);
    do_req(0, 12'h234, 4, 0, 0);              // R3 broadcast reset word
    do_req(0, 12'h01C, 4, 0, 0);              // R3 split low reset
    do_req(0, 12'h204, 4, 0, 0);              // R3 bus time reset
    // R4 masks
    do_req(1, 12'h018, 4, 32'hFFFF_FFFF, 0);
    do_req(0, 12'h018, 4, 0, 0);
    do_req(1, 12'h01C, 4, 32'hFFFF_FFFF, 0);
    do_req(0, 12'h01C, 4, 0, 0);
    // R5/R6 wrap seen inside the same bus-time read
    do_req(0, 12'h200, 4, 0, 32'h1000_0000);
    do_req(0, 12'h204, 4, 0, 32'h0500_0000);
    do_req(1, 12'h204, 4, 32'h1234_56FF, 0);
    do_req(1, 12'h200, 4, 32'h7000_0000, 0);
    do_req(0, 12'h204, 4, 0, 32'h6FFF_FFFF);
    // R7, R8
    do_req(1, 12'h008, 4, 32'hABCD_EF01, 0);
    do_req(0, 12'h008, 4, 0, 0);
    do_req(1, 12'h234, 4, 32'hFFFF_FFFF, 0);
    do_req(0, 12'h234, 4, 0, 0);
    do_req(1, 12'h234, 4, 32'h0000_0000, 0);
    do_req(0, 12'h234, 4, 0, 0);
    // R9, R10, R2
    do_req(0, 12'h00C, 4, 0, 0);
    do_req(1, 12'h00C, 4, 32'hFFFF_FFFF, 0);
    do_req(1, 12'h000, 4, 32'hFFFF_FFFF, 0);
    do_req(0, 12'h004, 4, 0, 0);
    do_req(1, 12'h224, 4, 32'h0, 0);
    do_req(0, 12'h220, 4, 0, 0);
    do_req(0, 12'h210, 4, 0, 0);
    do_req(1, 12'h300, 4, 32'h1, 0);
    do_req(1, 12'h018, 2, 32'h5, 0);
    do_req(0, 12'h01A, 4, 0, 0);

    // R1 back-pressure: stalled response, pending node-ID write
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_offset = 12'h234; req_len = 4;
    @(negedge clk);
    req_write = 1; req_offset = 12'h008; req_wdata = 32'h0040_0000;
    chk(req_ready === 1'b0, "R1 ready low", 32'(req_ready), 32'd0);
    repeat (2) begin
      @(negedge clk);
      chk(rsp_valid === 1'b1 && rsp_rdata === m_bcast, "R1 hold", rsp_rdata, m_bcast);
      chk(bus_id_out === m_bus, "R1 write waits", 32'(bus_id_out), 32'(m_bus));
    end
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    m_bus = 10'h001;
    chk(rsp_valid === 1'b1 && rsp_code === 3'd0, "R1 second rsp", 32'(rsp_code), 32'd0);
    chk(bus_id_out === m_bus, "R7 after stall", 32'(bus_id_out), 32'(m_bus));

    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [11:0] o, l;
      logic [31:0] c;
      o = ($urandom % 5 == 0) ? 12'($urandom) : offs[$urandom % 16];
      l = ($urandom % 8 == 0) ? 12'($urandom) : 12'd4;
      if ($urandom % 6 == 0) c = m_last - 32'($urandom % 32'h0400_0000) - 1;
      else c = m_last + 32'($urandom % 32'h0100_0000);
      do_req(1'($urandom), o, l, $urandom, c);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule